// File: doc/BRIEF.md
# Multi-Compare Tick Timer with AHB-Lite Slave Port

This block is a memory-mapped timer for a processor subsystem. One 64-bit time count is shared by every channel. It advances once every (prescale + 1) bus clocks. The count only begins to run when software first programs the prescale value. After that, the prescale value is locked until the next reset.

Each channel has its own 64-bit compare value. When the time count equals a compare value, that channel's pending flag goes high and stays high. It clears only when software writes either half of that compare value. A per-channel enable mask selects which pending flags drive the single interrupt line. Software can therefore poll the flags, take interrupts, or do both.

The bus side is an AHB-Lite slave that never inserts wait states and always answers OKAY. Every beat is handled as an independent single access.

Top module: `tick_timer`

## Requirements
- R1: After reset, the registers read as follows: prescale 0, time 0, enable mask 0, pending 0, and every compare value all ones. The interrupt output is low.
- R2: Registers sit at these 32-bit words (byte offsets):
  - prescale at 0x00;
  - pending flags at 0x08, read-only, bit n for channel n;
  - enable mask at 0x0C, bit n for channel n;
  - time low/high at 0x10/0x14;
  - compare n low/high at 0x18+8n and 0x1C+8n.

  Any other offset inside the window reads 0.
- R3: No access takes place in the following cases: the slave is not selected, the transfer type is IDLE (00) or BUSY (01), or the address phase occurs while the ready input is low. The ready output is always 1 and the response is always 0 (OKAY).
- R4: The time count holds its value from reset until the first write to the prescale register.
- R5: After the first prescale write with value P, time equals floor(k/(P+1)), where k is the number of clocks since the write took effect.
- R6: Every prescale write after the first one in a reset period leaves the prescale value unchanged.
- R7: Software can write either half of the time count. A write replaces that half, leaves the other half alone, wins over any increment in the same cycle, and restarts the prescale interval.
- R8: A channel's pending flag sets on the clock after the time count equals its compare value. It then stays set after the time count moves past that value.
- R9: A write to either half of a compare value clears that channel's pending flag. In a cycle where a clearing write and a match coincide, the write wins.
- R10: Enable and pending bits above the channel count read 0, and writes to them have no effect.
- R11: The interrupt output is high exactly when some channel has both its pending flag and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset, sampled on the clock |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type; bit 1 marks an active beat |
| haddr | input | ADDR_W | Byte address |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size (full words assumed, ignored) |
| hburst | input | 3 | Burst type (ignored) |
| hprot | input | 4 | Protection attributes (ignored) |
| hwdata | input | DATA_W | Write data, data phase |
| hready | input | 1 | Bus-wide ready; qualifies address and data phases |
| hrdata | output | DATA_W | Read data for the captured address |
| hreadyout | output | 1 | Slave ready, tied high |
| hresp | output | 1 | Response, tied to OKAY |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a write to a compare value that lands in the very cycle the match would set the pending flag again. A prescale of 3 holds the time count on the target value for four clocks. The bench works out the exact clock of the match from the clock of the prescale write. It then overlaps a compare write with two back-to-back pipelined reads of the pending register. The first read must show the flag cleared, because the write won. The second read, one clock later, must show the flag set again, because the match is still present.

// File: rtl/tick_timer_pkg.sv
// Shared constants for the tick timer.
// Word indices are in 32-bit words from the block's base.
// Assumes compare channels follow the fixed registers, two words each.
package tick_timer_pkg;
    localparam int WORD_W    = 32;
    localparam int TIME_W    = 64;
    localparam int WRD_PRESC = 0;
    localparam int WRD_PEND  = 2;
    localparam int WRD_IEN   = 3;
    localparam int WRD_TIME  = 4;
    localparam int WRD_CMP   = 6;

    // number of 32-bit words the map occupies for a channel count
    function automatic int map_words(input int ntmr);
        return WRD_CMP + 2 * ntmr;
    endfunction
endpackage

// File: rtl/tt_bus_port.sv
// Address-phase capture for the AHB-Lite slave.
// Records select, direction and word offset while hready is high.
// The top applies writes and drives read data from the captured values.
// Assumes no wait states from this slave; hready comes from the interconnect.
module tt_bus_port #(
    parameter int ADDR_W = 32,
    parameter int WI     = 4
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic              hready,
    output logic              dp_act,
    output logic              dp_wr,
    output logic [WI-1:0]     dp_woff
);
    localparam int HI_BITS = ADDR_W - WI - 2;

    // Capture the address phase of NONSEQ/SEQ beats that are selected
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            dp_act  <= 1'b0;
            dp_wr   <= 1'b0;
            dp_woff <= '0;
        end else if (hready) begin
            dp_act  <= hsel & htrans[1];
            dp_wr   <= hwrite;
            dp_woff <= haddr[WI+1:2];
        end
    end

    logic unused_lo;
    assign unused_lo = ^{haddr[1:0], htrans[0]};

    generate
        if (HI_BITS > 0) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^haddr[ADDR_W-1:WI+2];
        end
    endgenerate

    // R3
    capture_hold_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        !hready |=> ($stable(dp_act) && $stable(dp_woff)));
endmodule

// File: rtl/tt_timebase.sv
// Prescaler and shared 64-bit time count.
// The prescale value is taken from the first write after reset and then locked.
// Time runs only after that first write. A time write replaces the addressed
// half, wins over the increment and restarts the prescale interval.
module tt_timebase
    import tick_timer_pkg::*;
(
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              presc_we,
    input  logic [WORD_W-1:0] presc_wd,
    input  logic              tlo_we,
    input  logic              thi_we,
    input  logic [WORD_W-1:0] tlo_wd,
    input  logic [WORD_W-1:0] thi_wd,
    output logic [WORD_W-1:0] presc_q,
    output logic [TIME_W-1:0] time_q
);
    logic              started;
    logic [WORD_W-1:0] div_cnt;
    logic              t_we;

    assign t_we = tlo_we | thi_we;

    // Latch the prescale value once and mark the count as running
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            presc_q <= '0;
            started <= 1'b0;
        end else if (presc_we && !started) begin
            presc_q <= presc_wd;
            started <= 1'b1;
        end
    end

    // Divide the bus clock and advance or overwrite the time count
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            div_cnt <= '0;
            time_q  <= '0;
        end else if (t_we) begin
            div_cnt <= '0;
            time_q  <= {thi_we ? thi_wd : time_q[TIME_W-1:WORD_W],
                        tlo_we ? tlo_wd : time_q[WORD_W-1:0]};
        end else if (started) begin
            if (div_cnt == presc_q) begin
                div_cnt <= '0;
                time_q  <= time_q + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // R4
    time_hold_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (!started && !t_we) |=> $stable(time_q));

    // R6
    presc_lock_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        started |=> $stable(presc_q));

    // R5
    time_step_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (started && !t_we) |=> (time_q == $past(time_q) || time_q == $past(time_q) + 1'b1));
endmodule

// File: rtl/tt_cmp_bank.sv
// Compare values and sticky pending flags, one per channel.
// A flag sets on the clock after the time count equals its compare value.
// A write to either compare half clears it; the write wins over a match.
// Compare values reset to all ones so that no channel matches out of reset.
module tt_cmp_bank
    import tick_timer_pkg::*;
#(
    parameter int NUM_TMR = 3
) (
    input  logic                             hclk,
    input  logic                             hresetn,
    input  logic [TIME_W-1:0]                time_q,
    input  logic [NUM_TMR-1:0]               lo_we,
    input  logic [NUM_TMR-1:0]               hi_we,
    input  logic [NUM_TMR-1:0][WORD_W-1:0]   lo_wd,
    input  logic [NUM_TMR-1:0][WORD_W-1:0]   hi_wd,
    output logic [NUM_TMR-1:0][TIME_W-1:0]   cmp_q,
    output logic [NUM_TMR-1:0]               pend_q
);
    generate
        for (genvar n = 0; n < NUM_TMR; n++) begin : g_ch
            logic hit;
            assign hit = (cmp_q[n] == time_q);

            // Hold this channel's compare value, written one half at a time
            always_ff @(posedge hclk) begin
                if (!hresetn) begin
                    cmp_q[n] <= '1;
                end else begin
                    if (lo_we[n]) cmp_q[n][WORD_W-1:0]      <= lo_wd[n];
                    if (hi_we[n]) cmp_q[n][TIME_W-1:WORD_W] <= hi_wd[n];
                end
            end

            // Set the sticky flag on a match, clear it on a compare write
            always_ff @(posedge hclk) begin
                if (!hresetn) begin
                    pend_q[n] <= 1'b0;
                end else if (lo_we[n] || hi_we[n]) begin
                    pend_q[n] <= 1'b0;
                end else if (hit) begin
                    pend_q[n] <= 1'b1;
                end
            end

            // R9
            pend_clr_chk: assert property (@(posedge hclk) disable iff (!hresetn)
                (lo_we[n] || hi_we[n]) |=> !pend_q[n]);

            // R8
            pend_sticky_chk: assert property (@(posedge hclk) disable iff (!hresetn)
                (pend_q[n] && !lo_we[n] && !hi_we[n]) |=> pend_q[n]);

            // R8
            pend_set_chk: assert property (@(posedge hclk) disable iff (!hresetn)
                (hit && !lo_we[n] && !hi_we[n]) |=> pend_q[n]);
        end
    endgenerate
endmodule

// File: rtl/tick_timer.sv
// Top level of the multi-compare tick timer: AHB-Lite slave, register
// decode, read mux, enable mask and interrupt combine.
// Assumes DATA_W is 32 or 64 and every access is a full bus word; narrower
// sizes, bursts and protection attributes are not looked at.
// Offsets wrap modulo the map window; the base is decoded outside.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [2:0]        hburst,
    input  logic [3:0]        hprot,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp,
    output logic              irq
);
    localparam int SPAN_B = map_words(NUM_TMR) * 4;
    localparam int WI     = $clog2(SPAN_B) - 2;
    localparam int NW     = 1 << WI;
    localparam int LANES  = DATA_W / WORD_W;
    localparam int LB     = $clog2(LANES);

    logic                           dp_act, dp_wr, dp_we;
    logic [WI-1:0]                  dp_woff;
    logic [WI-1:0]                  lane_idx [LANES];
    logic [NW-1:0]                  wwe;
    logic [WORD_W-1:0]              wwd   [NW];
    logic [WORD_W-1:0]              rword [NW];
    logic [WORD_W-1:0]              presc_q;
    logic [TIME_W-1:0]              time_q;
    logic [NUM_TMR-1:0]             ien_q;
    logic [NUM_TMR-1:0]             pend_q;
    logic [NUM_TMR-1:0][TIME_W-1:0] cmp_q;
    logic [NUM_TMR-1:0]             cmp_lo_we, cmp_hi_we;
    logic [NUM_TMR-1:0][WORD_W-1:0] cmp_lo_wd, cmp_hi_wd;

    assign hreadyout = 1'b1;
    assign hresp     = 1'b0;

    logic unused_ctl;
    assign unused_ctl = ^{hsize, hburst, hprot};

    tt_bus_port #(.ADDR_W(ADDR_W), .WI(WI)) u_port (
        .hclk    (hclk),
        .hresetn (hresetn),
        .hsel    (hsel),
        .htrans  (htrans),
        .haddr   (haddr),
        .hwrite  (hwrite),
        .hready  (hready),
        .dp_act  (dp_act),
        .dp_wr   (dp_wr),
        .dp_woff (dp_woff)
    );

    assign dp_we = dp_act & dp_wr & hready;

    // Word index served by each 32-bit lane of the data bus
    generate
        if (LB == 0) begin : g_one_lane
            assign lane_idx[0] = dp_woff;
        end else begin : g_multi_lane
            logic unused_lane;
            assign unused_lane = ^dp_woff[LB-1:0];
            for (genvar l = 0; l < LANES; l++) begin : g_lane
                assign lane_idx[l] = {dp_woff[WI-1:LB], LB'(l)};
            end
        end
    endgenerate

    // Spread the data-phase write over per-word strobes and data
    always_comb begin
        wwe = '0;
        for (int w = 0; w < NW; w++) wwd[w] = '0;
        for (int l = 0; l < LANES; l++) begin
            if (dp_we) wwe[lane_idx[l]] = 1'b1;
            wwd[lane_idx[l]] = hwdata[l*WORD_W +: WORD_W];
        end
    end

    tt_timebase u_tb (
        .hclk     (hclk),
        .hresetn  (hresetn),
        .presc_we (wwe[WRD_PRESC]),
        .presc_wd (wwd[WRD_PRESC]),
        .tlo_we   (wwe[WRD_TIME]),
        .thi_we   (wwe[WRD_TIME+1]),
        .tlo_wd   (wwd[WRD_TIME]),
        .thi_wd   (wwd[WRD_TIME+1]),
        .presc_q  (presc_q),
        .time_q   (time_q)
    );

    generate
        for (genvar n = 0; n < NUM_TMR; n++) begin : g_cw
            assign cmp_lo_we[n] = wwe[WRD_CMP + 2*n];
            assign cmp_hi_we[n] = wwe[WRD_CMP + 2*n + 1];
            assign cmp_lo_wd[n] = wwd[WRD_CMP + 2*n];
            assign cmp_hi_wd[n] = wwd[WRD_CMP + 2*n + 1];
        end
    endgenerate

    tt_cmp_bank #(.NUM_TMR(NUM_TMR)) u_cmp (
        .hclk    (hclk),
        .hresetn (hresetn),
        .time_q  (time_q),
        .lo_we   (cmp_lo_we),
        .hi_we   (cmp_hi_we),
        .lo_wd   (cmp_lo_wd),
        .hi_wd   (cmp_hi_wd),
        .cmp_q   (cmp_q),
        .pend_q  (pend_q)
    );

    // Enable mask; only implemented channel bits are stored
    always_ff @(posedge hclk) begin
        if (!hresetn) ien_q <= '0;
        else if (wwe[WRD_IEN]) ien_q <= wwd[WRD_IEN][NUM_TMR-1:0];
    end

    // Assemble the readable word map
    always_comb begin
        for (int w = 0; w < NW; w++) rword[w] = '0;
        rword[WRD_PRESC]  = presc_q;
        rword[WRD_PEND]   = WORD_W'(pend_q);
        rword[WRD_IEN]    = WORD_W'(ien_q);
        rword[WRD_TIME]   = time_q[WORD_W-1:0];
        rword[WRD_TIME+1] = time_q[TIME_W-1:WORD_W];
        for (int n = 0; n < NUM_TMR; n++) begin
            rword[WRD_CMP + 2*n]     = cmp_q[n][WORD_W-1:0];
            rword[WRD_CMP + 2*n + 1] = cmp_q[n][TIME_W-1:WORD_W];
        end
    end

    // Drive each lane of read data from the captured word offset
    always_comb begin
        for (int l = 0; l < LANES; l++) hrdata[l*WORD_W +: WORD_W] = rword[lane_idx[l]];
    end

    assign irq = |(pend_q & ien_q);

    // R11
    irq_src_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        irq |-> (pend_q != '0 && ien_q != '0));
endmodule

// File: tb/tick_timer_bench.sv
// Self-checking bench: prescale sweep, exact match timing, write-versus-match
// collision, enable masking and ignored transfers, on three channels, 32-bit bus.
module tick_timer_bench;
    localparam int NT = 3;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic [31:0] haddr = '0;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'b010;
    logic [2:0]  hburst = 3'b000;
    logic [3:0]  hprot = 4'b0011;
    logic [31:0] hwdata = '0;
    logic        hready = 1'b1;
    logic [31:0] hrdata;
    logic        hreadyout, hresp, irq;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 hclk = ~hclk;
    always @(posedge hclk) cyc <= cyc + 1;

    tick_timer #(.NUM_TMR(NT), .ADDR_W(32), .DATA_W(32)) u_tick_timer (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans), .haddr(haddr),
        .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hprot(hprot),
        .hwdata(hwdata), .hready(hready), .hrdata(hrdata),
        .hreadyout(hreadyout), .hresp(hresp), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic do_reset();
        hresetn = 1'b0;
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hready = 1'b1;
        repeat (3) @(negedge hclk);
        hresetn = 1'b1;
    endtask

    // all bus tasks start and end just after a falling edge
    task automatic wr_q(input logic [31:0] a, input logic [31:0] d,
                        input logic s, input logic [1:0] tr, input logic rdy);
        hsel = s; htrans = tr; hwrite = 1'b1; haddr = a; hready = rdy;
        @(posedge hclk); @(negedge hclk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hready = 1'b1; hwdata = d;
        @(posedge hclk); @(negedge hclk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, output int e);
        wr_q(a, d, 1'b1, 2'b10, 1'b1);
        e = cyc;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d, output int at);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = a;
        @(posedge hclk); @(negedge hclk);
        d = hrdata; at = cyc;
        hsel = 1'b0; htrans = 2'b00;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge hclk);
    endtask

    initial begin
        repeat (100000) @(posedge hclk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        int at, e, ew, eh, t;
        longint unsigned lo_at_eh;

        // ---------- reset state and map (R1, R2) ----------
        do_reset();
        chk("R1 irq after reset", irq, 1'b0);
        rd(32'h00, v, at); chk("R1 prescale reset", v, 0);
        rd(32'h04, v, at); chk("R2 reserved word 0x04", v, 0);
        rd(32'h08, v, at); chk("R1 pending reset", v, 0);
        rd(32'h0C, v, at); chk("R1 enable reset", v, 0);
        rd(32'h10, v, at); chk("R1 time low reset", v, 0);
        rd(32'h14, v, at); chk("R1 time high reset", v, 0);
        for (int n = 0; n < NT; n++) begin
            rd(32'h18 + 8*n, v, at); chk("R1 compare low reset", v, 32'hFFFF_FFFF);
            rd(32'h1C + 8*n, v, at); chk("R1 compare high reset", v, 32'hFFFF_FFFF);
        end
        rd(32'h30, v, at); chk("R2 unmapped word 0x30", v, 0);
        rd(32'h3C, v, at); chk("R2 unmapped word 0x3C", v, 0);

        // ---------- ignored transfers (R3) and held count (R4) ----------
        chk("R3 hreadyout high", hreadyout, 1'b1);
        chk("R3 hresp okay", hresp, 1'b0);
        wr_q(32'h00, 32'd5, 1'b0, 2'b10, 1'b1);
        wr_q(32'h00, 32'd5, 1'b1, 2'b00, 1'b1);
        wr_q(32'h00, 32'd5, 1'b1, 2'b01, 1'b1);
        wr_q(32'h00, 32'd5, 1'b1, 2'b10, 1'b0);
        wr_q(32'h0C, 32'd7, 1'b0, 2'b11, 1'b1);
        rd(32'h00, v, at); chk("R3 ignored prescale writes", v, 0);
        rd(32'h0C, v, at); chk("R3 ignored enable write", v, 0);
        repeat (25) @(negedge hclk);
        rd(32'h10, v, at); chk("R4 time held before prescale write", v, 0);

        // ---------- prescale sweep (R5, R6) ----------
        for (int p = 0; p < 5; p++) begin
            do_reset();
            wr(32'h00, p, e);
            wr(32'h00, p + 7, ew);
            rd(32'h00, v, at); chk("R6 second prescale write ignored", v, p);
            for (int k = 0; k < 10; k++) begin
                repeat (k * 3) @(negedge hclk);
                rd(32'h10, v, at);
                chk("R5 time after prescale", v, (at - e) / (p + 1));
            end
        end

        // ---------- time writes (R7) ----------
        do_reset();
        wr(32'h00, 32'd2, e);
        repeat (7) @(negedge hclk);
        wr(32'h10, 32'd1000, ew);
        rd(32'h10, v, at); chk("R7 time low after write", v, 1000 + (at - ew) / 3);
        repeat (4) @(negedge hclk);
        wr(32'h14, 32'd5, eh);
        lo_at_eh = 1000 + (eh - 1 - ew) / 3;
        rd(32'h14, v, at); chk("R7 time high after write", v, 5);
        rd(32'h10, v, at); chk("R7 low half kept across high write", v, lo_at_eh + (at - eh) / 3);

        // ---------- compare, pending, enables, interrupt (R8-R11) ----------
        do_reset();
        wr(32'h00, 32'd3, e);
        t = e + 40 * 4;                       // clock where time first reaches 40
        wr(32'h1C, 32'd0, ew);
        wr(32'h18, 32'd40, ew);
        wr(32'h24, 32'd0, ew);
        wr(32'h20, 32'd45, ew);
        rd(32'h08, v, at); chk("R8 no pending before match", v, 0);
        wait_until(t - 1);
        rd(32'h08, v, at); chk("R8 pending not yet set on match clock", v, 0);
        rd(32'h08, v, at); chk("R8 pending set one clock after match", v, 1);
        // overlap a compare write with two pipelined reads of the pending word
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h1C;
        @(posedge hclk); @(negedge hclk);
        hwdata = 32'd0; hwrite = 1'b0; haddr = 32'h08;
        @(posedge hclk); @(negedge hclk);
        chk("R9 write wins over coinciding match", hrdata, 0);
        @(posedge hclk); @(negedge hclk);
        chk("R8 match still present sets pending again", hrdata, 1);
        hsel = 1'b0; htrans = 2'b00;
        wait_until(e + 50 * 4);
        rd(32'h08, v, at); chk("R8 pending sticky after time passes", v, 3);
        chk("R11 polling mode keeps irq low", irq, 1'b0);
        wr(32'h0C, 32'hFFFF_FFFF, ew);
        chk("R11 irq with enabled pending", irq, 1'b1);
        rd(32'h0C, v, at); chk("R10 unused enable bits read zero", v, 32'h7);
        wr(32'h0C, 32'h4, ew);
        chk("R11 irq masked when only idle channel enabled", irq, 1'b0);
        wr(32'h0C, 32'h2, ew);
        chk("R11 irq from channel 1", irq, 1'b1);
        wr(32'h20, 32'd1000, ew);
        chk("R9 low-half write clears and drops irq", irq, 1'b0);
        rd(32'h08, v, at); chk("R9 only channel 1 cleared", v, 1);
        wr(32'h1C, 32'd0, ew);
        rd(32'h08, v, at); chk("R9 high-half write clears channel 0", v, 0);
        wr(32'h2C, 32'd0, ew);
        rd(32'h10, v, at);
        wr(32'h28, v + 3, ew);
        wr(32'h0C, 32'hFFFF_FFF8 | 32'h4, ew);
        rd(32'h0C, v, at); chk("R10 only implemented enable written", v, 32'h4);
        repeat (30) @(negedge hclk);
        rd(32'h08, v, at); chk("R10 pending upper bits zero", v, 32'h4);
        chk("R11 irq from channel 2", irq, 1'b1);

        done = 1;
        summary();
    end
endmodule